// File: doc/BRIEF.md
# Digital 57 kHz Suppressed-Carrier Demodulator

This block takes a hard-limited, one-bit version of a band-pass filtered broadcast composite signal and recovers the suppressed 57 kHz subcarrier. It then demodulates the double-sideband signal to a one-bit baseband symbol per carrier period. The recovered carrier comes from a period-length oscillator. This is a counter whose terminal count is trimmed once per period by a proportional-plus-integral loop. The loop is driven by a Costas-style I/Q correlator, so the data polarity does not affect it.

The block runs from a 4.332 MHz system clock, which gives 76 clocks per nominal carrier period. For each period it emits a symbol and a symbol strobe. It also emits a bit-rate reference strobe on every 48th carrier period, which feeds the bit-clock recovery stage that follows. A lock flag reports whether the recovered phase has been stable with sufficient amplitude.

Top module: `subcarrier_costas_demod`

## Requirements
- R1: A synchronous reset clears the oscillator, the correlators and the loop integrator. In the cycle after reset, `lock_o`, `sym_o`, `sym_stb_o` and `bit_stb_o` are all 0.
- R2: `sym_stb_o` is a one-cycle pulse in the cycle after the last clock of each recovered period. The first period after reset is exactly 76 clocks long.
- R3: The in-phase reference is high for the first half of the recovered period. `sym_o` is 1 when the input agrees with that reference on at least half of the period's samples, and 0 otherwise. It is valid with `sym_stb_o`.
- R4: The phase detector ignores data polarity. An in-phase input whose data is inverted in random periods keeps every recovered period at exactly 76 clocks.
- R5: The quadrature reference is high from a quarter to three quarters of the period. An input that leads the recovered carrier makes the next period shorter than 76 clocks. An input that lags it makes the next period longer.
- R6: Every recovered period lies between 72 and 80 clocks. The loop integrator saturates at ±255, even under a large input frequency error.
- R7: An input carrier with a 77-clock period carrying random data is acquired, and `lock_o` asserts within 400 recovered periods.
- R8: A period is good when the magnitude of its phase error is at most 16 and the magnitude of its in-phase sum is at least 38. `lock_o` rises on the strobe that ends the 32nd consecutive good period, and changes only on symbol strobes.
- R9: Once locked, `lock_o` falls on the strobe that ends the 8th consecutive bad period. A constant input gives bad periods.
- R10: `bit_stb_o` pulses together with every 48th `sym_stb_o` after reset, and never without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 76 clocks per nominal carrier period |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Sliced subcarrier input |
| sym_o | output | 1 | Demodulated baseband symbol of the last period |
| sym_stb_o | output | 1 | One-cycle strobe marking a new symbol |
| bit_stb_o | output | 1 | Bit-rate reference strobe, one per 48 periods |
| lock_o | output | 1 | Carrier lock flag |

## Verification
Three things can land on the same period-end edge: the loss of lock, the bit-rate strobe and the symbol strobe. All of them are produced by one oscillator wrap. The bench locks onto an in-phase input and then switches the input to a constant level at period 88. The 8th bad period therefore ends on the 96th strobe, which is also the second bit-rate strobe. The bench then expects `lock_o` low and both strobes high in that same cycle. Earlier symbols are compared against the random data the bench generated, and every strobe spacing is compared with 76.

// File: rtl/sc_demod_pkg.sv
package sc_demod_pkg;

    function automatic int sat_sym(input int v, input int lim);
        if (v > lim) return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    function automatic int abs_int(input int v);
        return (v < 0) ? -v : v;
    endfunction

endpackage

// File: rtl/sc_nco.sv
module sc_nco #(
    parameter int PERIOD  = 76,
    parameter int MAX_ADJ = 4,
    parameter int LEN_W   = 7,
    parameter int ADJ_W   = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [ADJ_W-1:0] adj_i,
    output logic                    last_o,
    output logic                    i_ref_o,
    output logic                    q_ref_o
);
    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
    } nco_t;

    nco_t st_d, st_q;
    logic [LEN_W-1:0] half, qtr;
    int next_len;

    always_comb begin
        st_d     = st_q;
        half     = st_q.len >> 1;
        qtr      = st_q.len >> 2;
        last_o   = (st_q.cnt == st_q.len - 1'b1);
        i_ref_o  = (st_q.cnt < half);
        q_ref_o  = (st_q.cnt >= qtr) && (st_q.cnt < qtr + half);
        next_len = PERIOD + int'(adj_i);
        if (last_o) begin
            st_d.cnt = '0;
            st_d.len = LEN_W'(next_len);
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
            st_q.len <= LEN_W'(PERIOD);
        end else begin
            st_q <= st_d;
        end
    end

    p_len_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (int'(st_q.len) >= PERIOD - MAX_ADJ) && (int'(st_q.len) <= PERIOD + MAX_ADJ));

    p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < st_q.len);

endmodule

// File: rtl/sc_costas_pd.sv
module sc_costas_pd #(
    parameter int PERIOD  = 76,
    parameter int MAX_ADJ = 4,
    parameter int SUM_W   = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    din,
    input  logic                    i_ref_i,
    input  logic                    q_ref_i,
    input  logic                    last_i,
    output logic signed [SUM_W-1:0] i_sum_o,
    output logic signed [SUM_W-1:0] err_o,
    output logic                    sym_o,
    output logic                    stb_o
);
    typedef struct packed {
        logic signed [SUM_W-1:0] i_acc;
        logic signed [SUM_W-1:0] q_acc;
        logic                    sym;
        logic                    stb;
    } pd_t;

    pd_t st_d, st_q;
    logic signed [SUM_W-1:0] i_term, q_term, q_tot;

    always_comb begin
        st_d    = st_q;
        i_term  = (din == i_ref_i) ? SUM_W'(1) : -SUM_W'(1);
        q_term  = (din == q_ref_i) ? SUM_W'(1) : -SUM_W'(1);
        i_sum_o = st_q.i_acc + i_term;
        q_tot   = st_q.q_acc + q_term;
        // Costas product: quadrature sum signed by the in-phase decision
        err_o   = (i_sum_o >= 0) ? q_tot : -q_tot;
        st_d.stb = last_i;
        if (last_i) begin
            st_d.i_acc = '0;
            st_d.q_acc = '0;
            st_d.sym   = (i_sum_o >= 0);
        end else begin
            st_d.i_acc = i_sum_o;
            st_d.q_acc = q_tot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sym_o = st_q.sym;
    assign stb_o = st_q.stb;

    p_acc_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(st_q.i_acc) <= PERIOD + MAX_ADJ) && (int'(st_q.i_acc) >= -(PERIOD + MAX_ADJ)));

    p_acc_cleared_r2: assert property (@(posedge clk) disable iff (rst)
        stb_o |-> (st_q.i_acc == '0) && (st_q.q_acc == '0));

endmodule

// File: rtl/sc_loop_filter.sv
module sc_loop_filter
    import sc_demod_pkg::*;
#(
    parameter int SUM_W    = 9,
    parameter int ADJ_W    = 5,
    parameter int INT_W    = 10,
    parameter int INT_LIM  = 255,
    parameter int KP_SHIFT = 3,
    parameter int KI_SHIFT = 5,
    parameter int MAX_ADJ  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    last_i,
    input  logic signed [SUM_W-1:0] err_i,
    output logic signed [ADJ_W-1:0] adj_o
);
    typedef struct packed {
        logic signed [INT_W-1:0] integ;
    } lf_t;

    lf_t st_d, st_q;
    int integ_n, ctrl;

    always_comb begin
        st_d    = st_q;
        integ_n = sat_sym(int'(st_q.integ) + int'(err_i), INT_LIM);
        ctrl    = (int'(err_i) >>> KP_SHIFT) + (integ_n >>> KI_SHIFT);
        adj_o   = ADJ_W'(sat_sym(ctrl, MAX_ADJ));
        if (last_i) begin
            st_d.integ = INT_W'(integ_n);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_integ_sat_r6: assert property (@(posedge clk) disable iff (rst)
        (int'(st_q.integ) <= INT_LIM) && (int'(st_q.integ) >= -INT_LIM));

    p_integ_moves_at_end_r6: assert property (@(posedge clk) disable iff (rst)
        !last_i |=> $stable(st_q.integ));

endmodule

// File: rtl/sc_lock_det.sv
module sc_lock_det
    import sc_demod_pkg::*;
#(
    parameter int SUM_W    = 9,
    parameter int ERR_TH   = 16,
    parameter int AMP_MIN  = 38,
    parameter int LOCK_N   = 32,
    parameter int UNLOCK_N = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    last_i,
    input  logic signed [SUM_W-1:0] i_sum_i,
    input  logic signed [SUM_W-1:0] err_i,
    output logic                    lock_o
);
    localparam int CNT_MAX = (LOCK_N > UNLOCK_N) ? LOCK_N : UNLOCK_N;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] good;
        logic [CNT_W-1:0] bad;
        logic             lock;
    } ld_t;

    ld_t st_d, st_q;
    logic good_per;

    always_comb begin
        st_d     = st_q;
        good_per = (abs_int(int'(err_i)) <= ERR_TH) && (abs_int(int'(i_sum_i)) >= AMP_MIN);
        if (last_i) begin
            if (good_per) begin
                st_d.bad  = '0;
                st_d.good = (st_q.good < CNT_W'(LOCK_N)) ? st_q.good + 1'b1 : st_q.good;
            end else begin
                st_d.good = '0;
                st_d.bad  = (st_q.bad < CNT_W'(UNLOCK_N)) ? st_q.bad + 1'b1 : st_q.bad;
            end
            if (!st_q.lock && st_d.good == CNT_W'(LOCK_N)) st_d.lock = 1'b1;
            if (st_q.lock && st_d.bad == CNT_W'(UNLOCK_N)) st_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o = st_q.lock;

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (int'(st_q.good) <= LOCK_N) && (int'(st_q.bad) <= UNLOCK_N));

    p_lock_rise_needs_run_r8: assert property (@(posedge clk) disable iff (rst)
        (!st_q.lock && last_i && !good_per) |=> !st_q.lock);

endmodule

// File: rtl/subcarrier_costas_demod.sv
module subcarrier_costas_demod #(
    parameter int PERIOD   = 76,
    parameter int MAX_ADJ  = 4,
    parameter int KP_SHIFT = 3,
    parameter int KI_SHIFT = 5,
    parameter int INT_LIM  = 255,
    parameter int ERR_TH   = 16,
    parameter int AMP_MIN  = 38,
    parameter int LOCK_N   = 32,
    parameter int UNLOCK_N = 8,
    parameter int BIT_DIV  = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic sym_o,
    output logic sym_stb_o,
    output logic bit_stb_o,
    output logic lock_o
);
    localparam int LEN_W = $clog2(PERIOD + MAX_ADJ + 1);
    localparam int SUM_W = LEN_W + 2;
    localparam int ADJ_W = $clog2(MAX_ADJ + 1) + 2;
    localparam int INT_W = $clog2(INT_LIM + 1) + 2;
    localparam int DIV_W = $clog2(BIT_DIV);

    logic                    last, i_ref, q_ref;
    logic signed [ADJ_W-1:0] adj;
    logic signed [SUM_W-1:0] i_sum, err;

    sc_nco #(.PERIOD(PERIOD), .MAX_ADJ(MAX_ADJ), .LEN_W(LEN_W), .ADJ_W(ADJ_W)) u_nco (
        .clk(clk), .rst(rst), .adj_i(adj),
        .last_o(last), .i_ref_o(i_ref), .q_ref_o(q_ref)
    );

    sc_costas_pd #(.PERIOD(PERIOD), .MAX_ADJ(MAX_ADJ), .SUM_W(SUM_W)) u_pd (
        .clk(clk), .rst(rst), .din(din), .i_ref_i(i_ref), .q_ref_i(q_ref),
        .last_i(last), .i_sum_o(i_sum), .err_o(err), .sym_o(sym_o), .stb_o(sym_stb_o)
    );

    sc_loop_filter #(.SUM_W(SUM_W), .ADJ_W(ADJ_W), .INT_W(INT_W), .INT_LIM(INT_LIM),
                     .KP_SHIFT(KP_SHIFT), .KI_SHIFT(KI_SHIFT), .MAX_ADJ(MAX_ADJ)) u_lf (
        .clk(clk), .rst(rst), .last_i(last), .err_i(err), .adj_o(adj)
    );

    sc_lock_det #(.SUM_W(SUM_W), .ERR_TH(ERR_TH), .AMP_MIN(AMP_MIN),
                  .LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_lock (
        .clk(clk), .rst(rst), .last_i(last), .i_sum_i(i_sum), .err_i(err), .lock_o(lock_o)
    );

    typedef struct packed {
        logic [DIV_W-1:0] pcnt;
        logic             bstb;
    } div_t;

    div_t dv_d, dv_q;

    always_comb begin
        dv_d      = dv_q;
        dv_d.bstb = 1'b0;
        if (last) begin
            if (dv_q.pcnt == DIV_W'(BIT_DIV - 1)) begin
                dv_d.pcnt = '0;
                dv_d.bstb = 1'b1;
            end else begin
                dv_d.pcnt = dv_q.pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dv_q <= '0;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign bit_stb_o = dv_q.bstb;

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!lock_o && !sym_stb_o && !bit_stb_o && !sym_o));

    p_bit_with_sym_r10: assert property (@(posedge clk) disable iff (rst)
        bit_stb_o |-> sym_stb_o);

    p_lock_moves_at_stb_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (lock_o != $past(lock_o))) |-> sym_stb_o);

    p_stb_single_r2: assert property (@(posedge clk) disable iff (rst)
        sym_stb_o |=> !sym_stb_o);

endmodule

// File: tb/tb_subcarrier_costas_demod.sv
module tb_subcarrier_costas_demod;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic sym_o, sym_stb_o, bit_stb_o, lock_o;

    subcarrier_costas_demod dut (
        .clk(clk), .rst(rst), .din(din),
        .sym_o(sym_o), .sym_stb_o(sym_stb_o), .bit_stb_o(bit_stb_o), .lock_o(lock_o)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc, last_stb, gap, nstb;
    int g_per, g_ph, g_pidx, g_const_from;
    bit g_data, g_rand;
    bit data_hist [0:1023];
    logic o_stb, o_sym, o_lock, o_bit;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_sample();
        bit hi;
        if (g_ph == 0) begin
            if (g_rand) g_data = 1'($urandom % 2);
            if (g_pidx < 1024) data_hist[g_pidx] = g_data;
        end
        hi = (g_ph < g_per / 2);
        din = (g_pidx >= g_const_from) ? 1'b0 : (g_data ? hi : !hi);
        g_ph++;
        if (g_ph == g_per) begin
            g_ph = 0;
            g_pidx++;
        end
        cyc++;
    endtask

    task automatic step();
        @(negedge clk);
        o_stb = sym_stb_o; o_sym = sym_o; o_lock = lock_o; o_bit = bit_stb_o;
        if (o_stb) begin
            gap = cyc - last_stb;
            last_stb = cyc;
            nstb++;
        end
        if (o_bit && !o_stb) check(1'b0, "R10", "bit strobe without symbol strobe", 1, 0);
        drive_sample();
    endtask

    task automatic do_reset(input int per, input int ph0, input bit rnd, input int cfrom);
        @(negedge clk);
        rst = 1'b1;
        din = 1'b0;
        repeat (3) @(negedge clk);
        check(!lock_o && !sym_o && !sym_stb_o && !bit_stb_o, "R1", "outputs after reset",
              {lock_o, sym_o, sym_stb_o, bit_stb_o}, 0);
        rst = 1'b0;
        g_per = per; g_ph = ph0; g_pidx = 0; g_const_from = cfrom;
        g_rand = rnd; g_data = 1'b1;
        cyc = 0; last_stb = 0; nstb = 0;
        drive_sample();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed_dummy;
        bit seen_lock;
        int mn, mx;
        seed_dummy = $urandom(1187);

        // In-phase random data, then constant input from period 88 (R2 R3 R4 R8 R9 R10)
        do_reset(76, 0, 1'b1, 88);
        while (nstb < 100) begin
            step();
            if (o_stb) begin
                check(gap == 76, "R4", "period length with random data", gap, 76);
                if (nstb == 1) check(gap == 76, "R2", "first period length", gap, 76);
                if (nstb <= 88)
                    check(o_sym == data_hist[nstb-1], "R3", "symbol value", o_sym, data_hist[nstb-1]);
                if (nstb == 31) check(!o_lock, "R8", "lock before 32nd good period", o_lock, 0);
                if (nstb == 32) check(o_lock, "R8", "lock on 32nd good period", o_lock, 1);
                if (nstb == 47) check(!o_bit, "R10", "bit strobe at 47", o_bit, 0);
                if (nstb == 48) check(o_bit, "R10", "bit strobe at 48", o_bit, 1);
                if (nstb == 95) check(o_lock, "R9", "lock after 7 bad periods", o_lock, 1);
                if (nstb == 96) begin
                    check(!o_lock, "R9", "lock after 8 bad periods", o_lock, 0);
                    check(o_bit, "R10", "bit strobe with lock loss", o_bit, 1);
                end
            end
        end

        // Loop direction with random offsets (R5)
        for (int t = 0; t < 6; t++) begin
            int d;
            bit lead;
            d = 3 + int'($urandom % 13);
            lead = (t % 2 == 0);
            do_reset(76, lead ? d : 76 - d, 1'b0, 1 << 20);
            while (nstb < 2) begin
                step();
                if (o_stb && nstb == 1) check(gap == 76, "R2", "first period with offset", gap, 76);
                if (o_stb && nstb == 2) begin
                    if (lead) check(gap < 76, "R5", "leading input shortens period", gap, 75);
                    else      check(gap > 76, "R5", "lagging input lengthens period", gap, 77);
                end
            end
        end

        // Frequency offset tracking with random data (R7)
        do_reset(77, 0, 1'b1, 1 << 20);
        seen_lock = 1'b0;
        while (nstb < 400 && !seen_lock) begin
            step();
            if (o_stb && o_lock) seen_lock = 1'b1;
        end
        check(seen_lock, "R7", "lock on 77-clock carrier", seen_lock, 1);

        // Reset while locked (R1) then large frequency error (R6)
        do_reset(60, 0, 1'b0, 1 << 20);
        mn = 1000; mx = 0;
        while (nstb < 150) begin
            step();
            if (o_stb) begin
                if (gap < mn) mn = gap;
                if (gap > mx) mx = gap;
            end
        end
        check(mn >= 72, "R6", "shortest period", mn, 72);
        check(mx <= 80, "R6", "longest period", mx, 80);

        do_reset(76, 0, 1'b0, 1 << 20);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule